// File: doc/BRIEF.md
# Frame Sync Loss Monitor

This block sits on the link side of an audio codec and watches the frame sync line, sampled on the falling edge of the bit clock. A correct frame starts with a sync pulse that is high for exactly 16 bit-clock samples, and sync rises again exactly 256 samples after the previous rising edge. Any departure from this counts as a loss of synchronization. On a loss the block drops its link-ready flag, which also closes the register-access and capture-data gates.

Recovery needs two consecutive clean frames. A clean frame is a full 256-sample period whose pulse had the right width, and it is credited when the next on-time rising edge arrives. The same rule applies after reset.

Each rising edge of sync restarts the frame counter, so the block can lock onto a controller running at any phase. A mute request is raised during a loss when the loss-mute enable input is set. That input is expected to be held high by default.

Top module: `sync_loss_monitor`

## Requirements
- R1: After reset, ready_o, access_en_o, capture_en_o and mute_o are all low.
- R2: ready_o goes high at the sampled rising edge of sync that completes the second consecutive clean frame (three on-time rising edges, 256 samples apart, with correct pulses). It stays high until a violation.
- R3: A sync pulse sampled high for more than 16 consecutive samples is a violation, and ready_o drops.
- R4: A sync pulse sampled high for fewer than 16 samples is a violation, and ready_o drops.
- R5: A rising edge of sync fewer than 256 samples after the previous one is a violation. That edge becomes the start of a new frame, which can count as clean.
- R6: If sync does not rise on the 256th sample after the previous rising edge, that is a violation. The next rising edge only serves as the timing reference.
- R7: access_en_o and capture_en_o are high exactly when the link is synchronized (ready_o high).
- R8: mute_o is high when loss_mute_en_i is high and a violation has occurred that has not yet been followed by a return to ready. With loss_mute_en_i low, mute_o stays low.
- R9: A violation during recovery discards any clean frames already credited. Two new consecutive clean frames are then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; sync is sampled on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync from the link controller |
| loss_mute_en_i | input | 1 | Enables the mute request during loss |
| ready_o | output | 1 | Link synchronized flag |
| access_en_o | output | 1 | Register reads and writes permitted |
| capture_en_o | output | 1 | Capture data transmission permitted |
| mute_o | output | 1 | Output mute request during loss |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Pulses one sample too long and one sample too short. A width check that is off by one would miss one of them and keep ready high.
- A frame that arrives early, followed by one that is missing its edge. A design that does not restart its counter on the early edge would never relock. A design that treats the late edge as on time would count a frame too soon.
- A violation placed after one clean frame has already been credited during recovery. A design that keeps that credit would reassert ready one frame early.
- The mute enable toggled while the link is lost. A mute tied only to the ready state would show the wrong level.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;
  typedef struct packed {
    logic early;    // rising edge before end of frame
    logic missing;  // no rising edge at end of frame
    logic width;    // pulse not exactly the nominal width
  } sync_viol_t;
endpackage

// File: rtl/sync_edge_sampler.sv
module sync_edge_sampler (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o,
  output logic fall_o,
  output logic hold_o
);
  logic sync_q;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
  assign fall_o = ~sync_i & sync_q;
  assign hold_o = sync_i & sync_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned FRAME_LEN = 256
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic early_o,
  output logic missing_o,
  output logic on_time_o
);
  localparam int unsigned POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             ref_q;
  logic             at_end;

  assign at_end    = (pos_q == LAST);
  assign on_time_o = rise_i & ref_q & at_end;
  assign early_o   = rise_i & ref_q & ~at_end;
  assign missing_o = ~rise_i & ref_q & at_end;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      ref_q <= 1'b0;
    end else if (rise_i) begin
      pos_q <= '0;   // resync to every rising edge
      ref_q <= 1'b1;
    end else begin
      pos_q <= at_end ? '0 : pos_q + 1'b1;
      if (at_end) ref_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_width_check.sv
module pulse_width_check #(
  parameter int unsigned SYNC_HIGH = 16
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic hold_i,
  output logic bad_o
);
  localparam int unsigned HC_W = $clog2(SYNC_HIGH + 2);
  localparam logic [HC_W-1:0] NOM = HC_W'(SYNC_HIGH);
  localparam logic [HC_W-1:0] SAT = HC_W'(SYNC_HIGH + 1);

  logic [HC_W-1:0] hc_q;
  logic too_long, too_short;

  assign too_long  = hold_i & (hc_q == NOM);
  assign too_short = fall_i & (hc_q < NOM);
  assign bad_o     = too_long | too_short;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)                   hc_q <= '0;
    else if (rise_i)               hc_q <= HC_W'(1);
    else if (hold_i && hc_q != SAT) hc_q <= hc_q + 1'b1;
  end
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic on_time_i,
  input  logic viol_i,
  output logic ready_o,
  output logic lost_o
);
  localparam int unsigned CNT_W = $clog2(GOOD_FRAMES + 1);
  localparam logic [CNT_W-1:0] MAX = CNT_W'(GOOD_FRAMES);

  logic [CNT_W-1:0] cnt_q;
  logic frame_ok_q, ready_q, lost_q, credit;

  assign credit = on_time_i & frame_ok_q;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_ok_q <= 1'b0;
    else if (rise_i)  frame_ok_q <= 1'b1;
    else if (viol_i)  frame_ok_q <= 1'b0;
  end

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (viol_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      lost_q  <= 1'b1;
    end else if (credit) begin
      if (cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= MAX - 1'b1) begin
        ready_q <= 1'b1;
        lost_q  <= 1'b0;
      end
    end
  end

  assign ready_o = ready_q;
  assign lost_o  = lost_q;
endmodule

// File: rtl/sync_loss_monitor.sv
module sync_loss_monitor
  import sync_mon_pkg::*;
#(
  parameter int unsigned FRAME_LEN   = 256,
  parameter int unsigned SYNC_HIGH   = 16,
  parameter int unsigned GOOD_FRAMES = 2
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic loss_mute_en_i,
  output logic ready_o,
  output logic access_en_o,
  output logic capture_en_o,
  output logic mute_o
);
  sync_viol_t viol;
  logic rise, fall, hold, on_time, viol_any, early_viol, lost;

  sync_edge_sampler u_edge (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .rise_o(rise), .fall_o(fall), .hold_o(hold)
  );

  frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .rise_i(rise),
    .early_o(viol.early), .missing_o(viol.missing), .on_time_o(on_time)
  );

  pulse_width_check #(.SYNC_HIGH(SYNC_HIGH)) u_width (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .hold_i(hold), .bad_o(viol.width)
  );

  assign viol_any   = |viol;
  assign early_viol = viol.early;

  lock_tracker #(.GOOD_FRAMES(GOOD_FRAMES)) u_lock (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .rise_i(rise), .on_time_i(on_time),
    .viol_i(viol_any), .ready_o(ready_o), .lost_o(lost)
  );

  assign access_en_o  = ready_o;
  assign capture_en_o = ready_o;
  assign mute_o       = loss_mute_en_i & lost;
endmodule

// File: rtl/sync_loss_monitor_chk.sv
module sync_loss_monitor_chk (
  input logic bclk_i,
  input logic rst_ni,
  input logic sync_i,
  input logic loss_mute_en_i,
  input logic ready_o,
  input logic access_en_o,
  input logic mute_o,
  input logic viol_any,
  input logic early_viol
);
  // R3 R4 R6: any violation clears ready on the next sample
  assert_viol_drops_ready_R3: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    viol_any |=> !ready_o);

  assert_early_gates_access_R5: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    early_viol |=> !access_en_o);

  assert_ready_on_sync_edge_R2: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(sync_i));

  assert_ready_holds_R2: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (ready_o && !viol_any) |=> ready_o);

  assert_mute_only_in_loss_R8: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    mute_o |-> (!ready_o && loss_mute_en_i));
endmodule

bind sync_loss_monitor sync_loss_monitor_chk u_chk (
  .bclk_i(bclk_i), .rst_ni(rst_ni), .sync_i(sync_i),
  .loss_mute_en_i(loss_mute_en_i), .ready_o(ready_o),
  .access_en_o(access_en_o), .mute_o(mute_o),
  .viol_any(viol_any), .early_viol(early_viol)
);

// File: tb/tb_sync_loss_monitor.sv
`timescale 1ns/1ps
module tb_sync_loss_monitor;
  logic bclk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic loss_mute_en_i = 1'b1;
  logic ready_o, access_en_o, capture_en_o, mute_o;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 bclk_i = ~bclk_i;

  sync_loss_monitor dut (
    .bclk_i(bclk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .loss_mute_en_i(loss_mute_en_i), .ready_o(ready_o),
    .access_en_o(access_en_o), .capture_en_o(capture_en_o), .mute_o(mute_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // drive one frame: hi samples high, then low up to len
  task automatic frame(input int hi, input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge bclk_i);
      sync_i = (i < hi);
    end
    #1;
  endtask

  task automatic lock_up();
    frame(16, 256); frame(16, 256); frame(16, 256);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready_o, 1'b0);
    chk("R1 access", access_en_o, 1'b0);
    chk("R1 capture", capture_en_o, 1'b0);
    chk("R1 mute", mute_o, 1'b0);
  endtask

  task automatic t_initial_lock();
    frame(16, 256); frame(16, 256);
    chk("R2 not ready after two edges", ready_o, 1'b0);
    frame(16, 256);
    chk("R2 ready after two clean frames", ready_o, 1'b1);
    chk("R7 access open", access_en_o, 1'b1);
    chk("R7 capture open", capture_en_o, 1'b1);
    chk("R8 no mute when synced", mute_o, 1'b0);
  endtask

  task automatic t_long_pulse();
    frame(17, 256);
    chk("R3 long pulse drops ready", ready_o, 1'b0);
    chk("R7 access closed", access_en_o, 1'b0);
    chk("R7 capture closed", capture_en_o, 1'b0);
    chk("R8 mute in loss", mute_o, 1'b1);
    frame(16, 256); frame(16, 256);
    chk("R3 not yet relocked", ready_o, 1'b0);
    frame(16, 256);
    chk("R3 relocked", ready_o, 1'b1);
    chk("R8 mute released", mute_o, 1'b0);
  endtask

  task automatic t_short_pulse();
    frame(15, 256);
    chk("R4 short pulse drops ready", ready_o, 1'b0);
    lock_up();
    chk("R4 relocked", ready_o, 1'b1);
  endtask

  task automatic t_early();
    frame(16, 200);
    chk("R5 ready before early edge", ready_o, 1'b1);
    frame(16, 256);
    chk("R5 early edge drops ready", ready_o, 1'b0);
    frame(16, 256);
    chk("R5 one clean frame", ready_o, 1'b0);
    frame(16, 256);
    chk("R5 relock from early edge", ready_o, 1'b1);
  endtask

  task automatic t_missing();
    frame(16, 300);
    chk("R6 missing edge drops ready", ready_o, 1'b0);
    frame(16, 256); frame(16, 256);
    chk("R6 late edge is reference only", ready_o, 1'b0);
    frame(16, 256);
    chk("R6 relocked", ready_o, 1'b1);
  endtask

  task automatic t_restart();
    frame(17, 256);
    frame(16, 256);
    frame(15, 256);
    frame(16, 256); frame(16, 256);
    chk("R9 credit discarded", ready_o, 1'b0);
    frame(16, 256);
    chk("R9 relocked", ready_o, 1'b1);
  endtask

  task automatic t_mute_disable();
    loss_mute_en_i = 1'b0;
    frame(17, 256);
    chk("R8 ready low", ready_o, 1'b0);
    chk("R8 mute disabled", mute_o, 1'b0);
    loss_mute_en_i = 1'b1;
    #1;
    chk("R8 mute enabled in loss", mute_o, 1'b1);
    lock_up();
    chk("R8 mute cleared on relock", mute_o, 1'b0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge bclk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_initial_lock();
    t_long_pulse();
    t_short_pulse();
    t_early();
    t_missing();
    t_restart();
    t_mute_disable();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule